// File: doc/BRIEF.md
# DMA Destination Address Stepper with Peripheral Acknowledge

This block is one channel's transfer sequencer slice inside a DMA engine. It holds a control word and the destination address of the channel. It walks each transfer unit through its bus phases: a read phase followed by a write phase when the channel moves data between two addresses, or one combined phase when the peripheral side is addressed by the acknowledge strobe alone. It also produces that acknowledge strobe in the programmed phase and with the programmed polarity.

When a unit completes, the destination address moves by the unit size in bytes. It can go up, go down or stay put, and arithmetic wraps at 32 bits. Some combinations of direction and size are not allowed. The block flags these and refuses to start transfers until the channel is reprogrammed. The acknowledge phase and polarity bits exist only on channels whose index is below a parameterised limit. On the other channels those bits are tied to zero.

The control word uses these fields. Bit 0 selects dual (1) or single (0) address mode. Bits 2:1 give the size: 00 byte, 01 halfword, 10 word, 11 sixteen-byte burst. Bits 4:3 give the destination step: 00 fixed, 01 up, 10 down, 11 reserved. Bit 5 is the acknowledge phase: 0 read, 1 write. Bit 6 is the acknowledge polarity: 1 active-high, 0 active-low. Bit 7 gives the single-mode direction: 1 means data goes to the acknowledged device, 0 means data goes to memory. Bits 15:8 are reserved. The `phase` output encodes 00 idle, 01 read, 10 write and 11 single.

Top module: `dma_dst_stepper`

## Requirements
- R1: After a synchronous reset, `dst_addr`, `cfg_rdata`, `phase`, `cfg_err` and `unit_done` are all zero, and `ack` is 1, the idle level for active-low polarity.
- R2: `cfg_rdata` returns bits 7:0 as last written. Bits 15:8 always read 0.
- R3: In dual mode, `xfer_req` in idle moves `phase` to 01 on the next cycle. `phase_done` in 01 moves it to 10. `phase_done` in 10 returns it to 00, and `unit_done` is 1 for exactly the following cycle.
- R4: In single mode, `xfer_req` in idle moves `phase` to 11. `phase_done` returns it to 00 with a one-cycle `unit_done`.
- R5: With step 01, `dst_addr` grows by 1, 2, 4 or 16 for size 00, 01, 10 or 11. The update happens once per unit, on the edge that ends the final phase, and wraps modulo 2^32.
- R6: With step 10, `dst_addr` shrinks by 1, 2 or 4 for size 00, 01 or 10, with wraparound. With step 00 it does not change.
- R7: `cfg_err` is 1 after a control write with step 11, or with size 11 and step 00 or 10. It stays 0 for any setting with bit 0 = 0 and bit 7 = 1.
- R8: While `cfg_err` is 1, `xfer_req` leaves `phase` at 00, `ack` at its idle level and `dst_addr` unchanged. A later legal control write clears `cfg_err`.
- R9: In dual mode, `ack` is active during phase 01 only when bit 5 is 0, and during phase 10 only when bit 5 is 1.
- R10: In single mode, `ack` is active for the whole of phase 11, whatever the value of bit 5.
- R11: Bit 6 = 1 makes `ack` active-high. Bit 6 = 0 makes it active-low. In idle, `ack` shows the inactive level.
- R12: In single mode with bit 7 = 1, `dst_addr` is not updated, whatever the step field holds.
- R13: A control write or an address load issued while `phase` is not 00 has no effect.
- R14: On a channel with `CHAN_ID` not below `ACK_CFG_CHANS`, bits 6:5 read back 0 and their writes are ignored. Acknowledge is then active-low, and in dual mode it falls in the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| cfg_err | output | 1 | Prohibited setting flag |
| addr_wr | input | 1 | Destination address load strobe |
| addr_wdata | input | 32 | Destination address load value |
| dst_addr | output | 32 | Current destination address |
| xfer_req | input | 1 | Start one transfer unit |
| phase_done | input | 1 | The current bus phase completes this cycle |
| phase | output | 2 | Current phase: 00 idle, 01 read, 10 write, 11 single |
| unit_done | output | 1 | One-cycle pulse after a unit completes |
| ack | output | 1 | Peripheral acknowledge strobe |

## Verification
The hardest conditions to reach from the ports are the blocked and ignored paths. Examples are a start request on a channel holding a prohibited setting, or a reconfiguration attempt in the middle of a unit, where a fault shows up only as a missing change. The bench sweeps all 256 values of the low control byte through one full unit on two channels at once: one channel with acknowledge configuration and one without. Each pass also drives writes during the read phase and a start request while the error flag is set, and checks that phase, readback and address stay where they were. The address bases sit at both ends of the 32-bit range, so increments and decrements cross the wrap.

// File: rtl/dma_step_pkg.sv
// Shared types and helpers for the DMA destination stepper.
// Assumes the control field layout below is stable across all channels.
package dma_step_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_READ   = 2'b01,
        PH_WRITE  = 2'b10,
        PH_SINGLE = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        DM_FIXED = 2'b00,
        DM_INC   = 2'b01,
        DM_DEC   = 2'b10,
        DM_RSVD  = 2'b11
    } dmode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_16B  = 2'b11
    } size_e;

    // Control fields, MSB first: bit7 down to bit0.
    typedef struct packed {
        logic   to_dev;   // single mode: data flows to the acknowledged device
        logic   ack_pol;  // 1 active-high acknowledge
        logic   ack_wr;   // dual mode: acknowledge in write phase
        dmode_e dmode;    // destination step direction
        size_e  size;     // unit size
        logic   dual;     // 1 dual address, 0 single address
    } ctrl_t;

    // Unit size in bytes.
    function automatic logic [4:0] step_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: return 5'd1;
            SZ_HALF: return 5'd2;
            SZ_WORD: return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

    // True when the combination of fields is prohibited.
    function automatic logic setting_illegal(input ctrl_t c);
        if (!c.dual && c.to_dev) return 1'b0;  // step field unused here
        if (c.dmode == DM_RSVD) return 1'b1;
        if (c.size == SZ_16B && (c.dmode == DM_FIXED || c.dmode == DM_DEC)) return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
// Channel control register: stores the masked control fields, exposes a
// readback word with reserved bits at zero and decodes prohibited settings.
// Assumes CTRL_W is at least the field width (8). Writes are dropped while busy.
module dma_ctrl_reg
    import dma_step_pkg::*;
#(
    parameter int CTRL_W      = 16,
    parameter bit HAS_ACK_CFG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata,
    output logic              cfg_err
);
    localparam int FIELD_W = $bits(ctrl_t);

    ctrl_t wr_fields;
    ctrl_t masked;

    // Purpose: slice the implemented fields out of the write word.
    always_comb wr_fields = ctrl_t'(wdata[FIELD_W-1:0]);

    generate
        if (HAS_ACK_CFG) begin : g_ack_cfg
            // Purpose: acknowledge fields are writable on this channel.
            always_comb masked = wr_fields;
        end else begin : g_no_ack_cfg
            // Purpose: acknowledge fields are tied low on this channel.
            always_comb begin
                masked         = wr_fields;
                masked.ack_wr  = 1'b0;
                masked.ack_pol = 1'b0;
            end
        end
    endgenerate

    // Purpose: capture fields and the error decode on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            cfg_err <= 1'b0;
        end else if (wr_en && !busy) begin
            ctrl    <= masked;
            cfg_err <= setting_illegal(masked);
        end
    end

    // Purpose: readback with reserved bits zero.
    always_comb begin
        rdata              = '0;
        rdata[FIELD_W-1:0] = ctrl;
    end
endmodule

// File: rtl/dma_phase_seq.sv
// Phase sequencer: idle -> read -> write for dual transfers, idle -> single
// for single transfers. Each phase ends on phase_done. Assumes the caller
// blocks starts while the configuration is prohibited.
module dma_phase_seq
    import dma_step_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   xfer_req,
    input  logic   phase_done,
    input  logic   dual,
    input  logic   blocked,
    output phase_e phase,
    output logic   commit,
    output logic   unit_done
);
    logic start;

    // Purpose: qualify a start request.
    always_comb start = xfer_req && !blocked;

    // Purpose: the final phase of a unit completes this cycle.
    always_comb commit = phase_done && (phase == PH_WRITE || phase == PH_SINGLE);

    // Purpose: advance the phase state and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            unit_done <= 1'b0;
        end else begin
            unit_done <= commit;
            case (phase)
                PH_IDLE:   if (start) phase <= dual ? PH_READ : PH_SINGLE;
                PH_READ:   if (phase_done) phase <= PH_WRITE;
                PH_WRITE:  if (phase_done) phase <= PH_IDLE;
                PH_SINGLE: if (phase_done) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_addr_step.sv
// Destination address register: loaded while idle, stepped by the unit size
// once per completed unit. Arithmetic wraps at ADDR_W bits. Assumes ADDR_W > 5.
module dma_addr_step
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              busy,
    input  logic              commit,
    input  logic              hold,
    input  dmode_e            dmode,
    input  size_e             size,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] step;

    // Purpose: widen the byte step to the address width.
    always_comb step = ADDR_W'(step_bytes(size));

    // Purpose: load or step the destination address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load && !busy) begin
            addr <= load_addr;
        end else if (commit && !hold) begin
            case (dmode)
                DM_INC:  addr <= addr + step;
                DM_DEC:  addr <= addr - step;
                default: addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/dma_ack_gen.sv
// Acknowledge generator: decides from the phase and the mode bits whether
// the strobe is active, then applies polarity. Assumes phase is registered.
module dma_ack_gen
    import dma_step_pkg::*;
(
    input  phase_e phase,
    input  logic   ack_wr,
    input  logic   ack_pol,
    output logic   ack
);
    logic active;

    // Purpose: select the phase in which acknowledge is active.
    always_comb begin
        case (phase)
            PH_SINGLE: active = 1'b1;
            PH_READ:   active = !ack_wr;
            PH_WRITE:  active = ack_wr;
            default:   active = 1'b0;
        endcase
    end

    // Purpose: apply the programmed output polarity.
    always_comb ack = ack_pol ? active : !active;
endmodule

// File: rtl/dma_dst_stepper.sv
// Top of the per-channel destination stepper slice. It ties the control
// register, the phase sequencer, the address stepper and the acknowledge
// generator together. Assumes one unit is in flight at a time.
module dma_dst_stepper
    import dma_step_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int CTRL_W        = 16,
    parameter int CHAN_ID       = 0,
    parameter int ACK_CFG_CHANS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              cfg_err,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] dst_addr,
    input  logic              xfer_req,
    input  logic              phase_done,
    output logic [1:0]        phase,
    output logic              unit_done,
    output logic              ack
);
    localparam bit HAS_ACK_CFG = (CHAN_ID < ACK_CFG_CHANS);

    ctrl_t  ctrl;
    phase_e phase_q;
    logic   busy;
    logic   commit;
    logic   hold_addr;

    // Purpose: channel is mid-unit.
    always_comb busy = (phase_q != PH_IDLE);

    // Purpose: single transfers toward the device leave the address alone.
    always_comb hold_addr = !ctrl.dual && ctrl.to_dev;

    dma_ctrl_reg #(
        .CTRL_W      (CTRL_W),
        .HAS_ACK_CFG (HAS_ACK_CFG)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .busy    (busy),
        .wdata   (cfg_wdata),
        .ctrl    (ctrl),
        .rdata   (cfg_rdata),
        .cfg_err (cfg_err)
    );

    dma_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_req   (xfer_req),
        .phase_done (phase_done),
        .dual       (ctrl.dual),
        .blocked    (cfg_err),
        .phase      (phase_q),
        .commit     (commit),
        .unit_done  (unit_done)
    );

    dma_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_wr),
        .load_addr (addr_wdata),
        .busy      (busy),
        .commit    (commit),
        .hold      (hold_addr),
        .dmode     (ctrl.dmode),
        .size      (ctrl.size),
        .addr      (dst_addr)
    );

    dma_ack_gen u_ack (
        .phase   (phase_q),
        .ack_wr  (ctrl.ack_wr),
        .ack_pol (ctrl.ack_pol),
        .ack     (ack)
    );

    // Purpose: expose the phase code.
    always_comb phase = phase_q;
endmodule

// File: rtl/dma_dst_stepper_chk.sv
// Protocol checker for dma_dst_stepper, attached to every instance by bind.
module dma_dst_stepper_chk #(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] cfg_rdata,
    input logic              cfg_err,
    input logic              addr_wr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              xfer_req,
    input logic              phase_done,
    input logic [1:0]        phase,
    input logic              unit_done,
    input logic              ack
);
    logic past_ok;

    // Purpose: mark cycles that have a valid previous sample after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && phase_done) |=> (phase == 2'b10));

    p_done_after_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && unit_done) |-> ($past(phase_done) && $past(phase[1])));

    p_addr_moves_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dst_addr != $past(dst_addr)) |-> (unit_done || $past(addr_wr)));

    p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && cfg_err) |=> (phase == 2'b00));

    p_idle_ack_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && phase == 2'b00) |-> (ack == !cfg_rdata[6]));

    p_cfg_frozen_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && phase != 2'b00) |=> $stable(cfg_rdata));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cfg_rdata[CTRL_W-1:8] == '0));
endmodule

bind dma_dst_stepper dma_dst_stepper_chk #(
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .cfg_err    (cfg_err),
    .addr_wr    (addr_wr),
    .dst_addr   (dst_addr),
    .xfer_req   (xfer_req),
    .phase_done (phase_done),
    .phase      (phase),
    .unit_done  (unit_done),
    .ack        (ack)
);

// File: tb/dma_dst_stepper_tb.sv
// Sweeps every low control byte through one unit on a channel with
// acknowledge configuration (u_dut) and one without (u_dut_hi).
module dma_dst_stepper_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        addr_wr = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        xfer_req = 1'b0;
    logic        phase_done = 1'b0;

    logic [15:0] rd_lo, rd_hi;
    logic        err_lo, err_hi;
    logic [31:0] addr_lo, addr_hi;
    logic [1:0]  ph_lo, ph_hi;
    logic        done_lo, done_hi;
    logic        ack_lo, ack_hi;

    int errors = 0;
    int checks = 0;

    dma_dst_stepper #(.CHAN_ID(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_lo), .cfg_err(err_lo), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .dst_addr(addr_lo), .xfer_req(xfer_req),
        .phase_done(phase_done), .phase(ph_lo), .unit_done(done_lo), .ack(ack_lo)
    );

    dma_dst_stepper #(.CHAN_ID(2)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_hi), .cfg_err(err_hi), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .dst_addr(addr_hi), .xfer_req(xfer_req),
        .phase_done(phase_done), .phase(ph_hi), .unit_done(done_hi), .ack(ack_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Expected acknowledge level from the requirements.
    function automatic logic exp_ack(input logic [7:0] c, input logic [1:0] ph, input bit hi);
        logic wr_sel, pol, active;
        wr_sel = hi ? 1'b0 : c[5];
        pol    = hi ? 1'b0 : c[6];
        active = (ph == 2'b11) || (ph == 2'b01 && !wr_sel) || (ph == 2'b10 && wr_sel);
        return pol ? active : !active;
    endfunction

    task automatic check_acks(input logic [7:0] c, input logic [1:0] ph, input string req);
        chk({req, " ack ch0"}, {31'd0, ack_lo}, {31'd0, exp_ack(c, ph, 1'b0)});
        chk("R14 ack ch2", {31'd0, ack_hi}, {31'd0, exp_ack(c, ph, 1'b1)});
    endtask

    task automatic run_unit(input logic [7:0] c, input logic [31:0] base);
        logic        dual, todev, bad;
        logic [1:0]  sz, md;
        logic [31:0] step, exp_addr;
        string       areq;
        dual  = c[0];
        sz    = c[2:1];
        md    = c[4:3];
        todev = c[7];
        bad   = (md == 2'b11) || (sz == 2'b11 && (md == 2'b00 || md == 2'b10));
        if (!dual && todev) bad = 1'b0;
        step  = (sz == 2'b11) ? 32'd16 : (32'd1 << sz);
        if (!dual && todev)  begin exp_addr = base;        areq = "R12"; end
        else if (md == 2'b01) begin exp_addr = base + step; areq = "R5"; end
        else if (md == 2'b10) begin exp_addr = base - step; areq = "R6"; end
        else                  begin exp_addr = base;        areq = "R6"; end

        // Control write with garbage in reserved bits.
        cfg_wr = 1'b1; cfg_wdata = {8'hA5, c};
        tick();
        cfg_wr = 1'b0;
        chk("R2 readback ch0", {16'd0, rd_lo}, {24'd0, c});
        chk("R14 readback ch2", {16'd0, rd_hi}, {24'd0, c & 8'h9F});
        chk("R7 err ch0", {31'd0, err_lo}, {31'd0, bad});
        chk("R7 err ch2", {31'd0, err_hi}, {31'd0, bad});
        check_acks(c, 2'b00, "R11");

        addr_wr = 1'b1; addr_wdata = base;
        tick();
        addr_wr = 1'b0;
        chk("R5 load", addr_lo, base);

        xfer_req = 1'b1;
        tick();
        xfer_req = 1'b0;

        if (bad) begin
            chk("R8 phase blocked", {30'd0, ph_lo}, 32'd0);
            chk("R8 addr blocked", addr_lo, base);
            check_acks(c, 2'b00, "R8");
            cfg_wr = 1'b1; cfg_wdata = 16'h0009;
            tick();
            cfg_wr = 1'b0;
            chk("R8 err cleared", {31'd0, err_lo}, 32'd0);
        end else if (dual) begin
            chk("R3 read phase", {30'd0, ph_lo}, 32'd1);
            chk("R3 read phase ch2", {30'd0, ph_hi}, 32'd1);
            check_acks(c, 2'b01, "R9");
            // Writes while busy must be dropped.
            cfg_wr = 1'b1; cfg_wdata = {8'h00, ~c};
            addr_wr = 1'b1; addr_wdata = 32'hDEAD_0000;
            tick();
            cfg_wr = 1'b0; addr_wr = 1'b0;
            chk("R13 cfg held", {16'd0, rd_lo}, {24'd0, c});
            chk("R13 addr held", addr_lo, base);
            chk("R13 phase held", {30'd0, ph_lo}, 32'd1);
            phase_done = 1'b1;
            tick();
            phase_done = 1'b0;
            chk("R3 write phase", {30'd0, ph_lo}, 32'd2);
            chk({areq, " no early update"}, addr_lo, base);
            check_acks(c, 2'b10, "R9");
            phase_done = 1'b1;
            tick();
            phase_done = 1'b0;
            chk("R3 idle", {30'd0, ph_lo}, 32'd0);
            chk("R3 unit_done", {31'd0, done_lo}, 32'd1);
            chk({areq, " addr ch0"}, addr_lo, exp_addr);
            chk({areq, " addr ch2"}, addr_hi, exp_addr);
            check_acks(c, 2'b00, "R11");
            tick();
            chk("R3 unit_done pulse", {31'd0, done_lo}, 32'd0);
            chk({areq, " single update"}, addr_lo, exp_addr);
        end else begin
            chk("R4 single phase", {30'd0, ph_lo}, 32'd3);
            check_acks(c, 2'b11, "R10");
            phase_done = 1'b1;
            tick();
            phase_done = 1'b0;
            chk("R4 idle", {30'd0, ph_lo}, 32'd0);
            chk("R4 unit_done", {31'd0, done_lo}, 32'd1);
            chk({areq, " addr ch0"}, addr_lo, exp_addr);
            chk({areq, " addr ch2"}, addr_hi, exp_addr);
            tick();
            chk("R4 unit_done pulse", {31'd0, done_hi}, 32'd0);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0000_0010;
        bases[1] = 32'hFFFF_FFF8;
        bases[2] = 32'h0000_0002;
        tick(); tick(); tick();
        chk("R1 addr", addr_lo, 32'd0);
        chk("R1 cfg", {16'd0, rd_lo}, 32'd0);
        chk("R1 phase", {30'd0, ph_lo}, 32'd0);
        chk("R1 err", {31'd0, err_lo}, 32'd0);
        chk("R1 done", {31'd0, done_lo}, 32'd0);
        chk("R1 ack", {31'd0, ack_lo}, 32'd1);
        rst_n = 1'b1;
        tick();
        for (int c = 0; c < 256; c++) begin
            run_unit(8'(c), bases[c % 3]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule